// File: doc/BRIEF.md
# Per-Task Zero-Overhead Loop Controller

This block sits beside the fetch stage of a pipelined core that interleaves instructions from up to four hardware tasks. Every task owns a private loop context. When a task issues a repeat instruction, its context captures a block length, a pass count and an arming mode. From then on it watches only instructions tagged with its own task ID. When the last instruction of the block issues, it tells the fetch stage, in the same cycle, to continue from the first instruction of the block. Each further pass therefore costs no cycles.

The block needs no spacer instructions. After the repeat instruction, a context stays in an arming state until a fixed number of its own task's instructions have issued: one in short mode and three in long mode. Instructions from other tasks are not counted, so the loop behaves the same under any slot schedule. The arming wait is paid once, not on every pass.

Each context has three states. In `LP_IDLE` it does nothing. In `LP_ARMING` it is loaded and counts its own task's instructions. In `LP_ACTIVE` it is armed and wraps at the end of the block. The transitions are:
- *launch*: any state goes to `LP_ARMING` on a repeat instruction.
- *arm*: `LP_ARMING` goes to `LP_ACTIVE` when the needed instruction count is reached.
- *finish*: `LP_ARMING` or `LP_ACTIVE` goes to `LP_IDLE` at the end of the last pass.
- *abort*: any state goes to `LP_IDLE` on cancel.

Top module: `task_loop_ctrl`

## Requirements
- R1: After reset every context is in `LP_IDLE`, and no redirect is produced whatever instructions issue.
- R2: A context is selected by the 2-bit task ID of the issuing instruction. An instruction from another task never causes that context to redirect.
- R3: Short mode (`rep_long`=0) allows wrapping once one instruction of the same task has issued after the repeat instruction. That instruction may itself be the end of the block.
- R4: Long mode (`rep_long`=1) allows wrapping only once three same-task instructions have issued after the repeat instruction. An end-of-block instruction that issues earlier passes through without a redirect, and instructions from other tasks do not advance the arming count.
- R5: A repeat instruction at address P with effective length E places the block at P+1 .. P+E. When an armed context sees its task issue address P+E, `redir_valid` is high in that same cycle and `redir_pc` equals P+1.
- R6: A pass count C of 1 or more gives exactly C-1 redirects. The end of the final pass does not redirect and returns the context to `LP_IDLE`, so later instructions at the block end do not redirect.
- R7: A pass count of 0 repeats without limit.
- R8: A pulse on `cancel[t]` returns context t to `LP_IDLE` at the next edge. It also suppresses any redirect for task t in that cycle.
- R9: A repeat instruction from a task whose context is busy restarts that context with the new parameters. The old block no longer redirects.
- R10: The effective length E is the larger of `rep_len` and the arming need (1 in short mode, 3 in long mode).
- R11: A redirect appears only in a cycle with `iss_valid` high and `rep_start` low, and its target is never above the issuing address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| iss_valid | input | 1 | An instruction issues this cycle |
| iss_task | input | 2 | Task ID of the issuing instruction |
| iss_pc | input | 16 | Address of the issuing instruction |
| rep_start | input | 1 | The issuing instruction is a repeat instruction |
| rep_long | input | 1 | Arming mode of the repeat: 0 short, 1 long |
| rep_len | input | 8 | Number of instructions in the block |
| rep_count | input | 16 | Number of passes (0 means unlimited) |
| cancel | input | 4 | Per-task abort pulse |
| redir_valid | output | 1 | Fetch must continue from `redir_pc` |
| redir_pc | output | 16 | Start address of the block being repeated |

## Verification
The hardest case to reach is an end-of-block instruction that issues while its context is still arming. In straight-line code the block is never shorter than the arming need, so that case does not arise. The stimulus therefore drives a task's issue address straight to the block end right after the repeat instruction. Instructions from other tasks are mixed in to show that they leave the arming count unchanged. The random phase runs one virtual program per task, each following its own predicted redirects. Occasional jumps and cancels, plus restarts aimed at busy contexts, keep all four contexts in overlapping states.

// File: rtl/loop_ctrl_pkg.sv
package loop_ctrl_pkg;

    typedef enum logic [1:0] {
        LP_IDLE   = 2'd0,
        LP_ARMING = 2'd1,
        LP_ACTIVE = 2'd2
    } loop_state_e;

    // Same-task instructions that must issue before the first wrap.
    localparam int SHORT_ARM = 1;
    localparam int LONG_ARM  = 3;

endpackage

// File: rtl/loop_task_ctx.sv
module loop_task_ctx
    import loop_ctrl_pkg::*;
#(
    parameter int PC_W  = 16,
    parameter int LEN_W = 8,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hit,
    input  logic             start,
    input  logic             abort,
    input  logic [PC_W-1:0]  pc,
    input  logic             long_mode,
    input  logic [LEN_W-1:0] len,
    input  logic [CNT_W-1:0] count,
    output logic             wrap,
    output logic [PC_W-1:0]  wrap_pc,
    output logic [1:0]       state
);

    localparam int ARM_W = $clog2(LONG_ARM + 1);
    localparam logic [ARM_W:0]   NEED_S  = (ARM_W+1)'(SHORT_ARM);
    localparam logic [ARM_W:0]   NEED_L  = (ARM_W+1)'(LONG_ARM);
    localparam logic [LEN_W-1:0] LNEED_S = LEN_W'(SHORT_ARM);
    localparam logic [LEN_W-1:0] LNEED_L = LEN_W'(LONG_ARM);
    localparam logic [ARM_W-1:0] ARM_SAT = ARM_W'(LONG_ARM);

    loop_state_e      st_q, st_d;
    logic [ARM_W-1:0] arm_q, arm_d;
    logic             long_q, long_d;
    logic             fvr_q, fvr_d;
    logic [PC_W-1:0]  beg_q, beg_d;
    logic [PC_W-1:0]  end_q, end_d;
    logic [CNT_W-1:0] rem_q, rem_d;

    logic             step;
    logic [ARM_W:0]   passed;
    logic [ARM_W:0]   need;
    logic             armed;
    logic             at_end;
    logic             more;
    logic [LEN_W-1:0] new_need;
    logic [LEN_W-1:0] eff_len;

    always_comb begin
        step     = hit && !start && !abort;
        passed   = {1'b0, arm_q} + 1'b1;
        need     = long_q ? NEED_L : NEED_S;
        armed    = (st_q == LP_ACTIVE) || ((st_q == LP_ARMING) && (passed >= need));
        at_end   = step && armed && (pc == end_q);
        more     = fvr_q || (rem_q > CNT_W'(1));
        new_need = long_mode ? LNEED_L : LNEED_S;
        eff_len  = (len < new_need) ? new_need : len;
    end

    // next-state logic
    always_comb begin
        st_d   = st_q;
        arm_d  = arm_q;
        long_d = long_q;
        fvr_d  = fvr_q;
        beg_d  = beg_q;
        end_d  = end_q;
        rem_d  = rem_q;
        if (abort) begin
            st_d = LP_IDLE;
        end else if (start) begin
            st_d   = LP_ARMING;
            arm_d  = '0;
            long_d = long_mode;
            fvr_d  = (count == '0);
            beg_d  = pc + PC_W'(1);
            end_d  = pc + PC_W'(eff_len);
            rem_d  = count;
        end else if (step) begin
            unique case (st_q)
                LP_IDLE: begin
                end
                LP_ARMING: begin
                    if (arm_q != ARM_SAT) arm_d = arm_q + 1'b1;
                    if (passed >= need)   st_d  = LP_ACTIVE;
                end
                LP_ACTIVE: begin
                end
                default: st_d = LP_IDLE;
            endcase
            if (at_end) begin
                if (!more)       st_d  = LP_IDLE;
                else if (!fvr_q) rem_d = rem_q - 1'b1;
            end
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= LP_IDLE;
            arm_q  <= '0;
            long_q <= 1'b0;
            fvr_q  <= 1'b0;
            beg_q  <= '0;
            end_q  <= '0;
            rem_q  <= '0;
        end else begin
            st_q   <= st_d;
            arm_q  <= arm_d;
            long_q <= long_d;
            fvr_q  <= fvr_d;
            beg_q  <= beg_d;
            end_q  <= end_d;
            rem_q  <= rem_d;
        end
    end

    // outputs
    always_comb begin
        wrap    = at_end && more;
        wrap_pc = beg_q;
        state   = st_q;
    end

endmodule

// File: rtl/loop_redirect_sel.sv
module loop_redirect_sel #(
    parameter int NT    = 4,
    parameter int TID_W = 2,
    parameter int PC_W  = 16
) (
    input  logic [NT-1:0]      wrap_vec,
    input  logic [NT*PC_W-1:0] pc_vec,
    input  logic [TID_W-1:0]   sel,
    output logic               valid,
    output logic [PC_W-1:0]    pc
);

    always_comb begin
        valid = |wrap_vec;
        pc    = pc_vec[sel*PC_W +: PC_W];
    end

endmodule

// File: rtl/task_loop_ctrl.sv
module task_loop_ctrl #(
    parameter int NUM_TASKS = 4,
    parameter int TID_W     = $clog2(NUM_TASKS),
    parameter int PC_W      = 16,
    parameter int LEN_W     = 8,
    parameter int CNT_W     = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 iss_valid,
    input  logic [TID_W-1:0]     iss_task,
    input  logic [PC_W-1:0]      iss_pc,
    input  logic                 rep_start,
    input  logic                 rep_long,
    input  logic [LEN_W-1:0]     rep_len,
    input  logic [CNT_W-1:0]     rep_count,
    input  logic [NUM_TASKS-1:0] cancel,
    output logic                 redir_valid,
    output logic [PC_W-1:0]      redir_pc
);

    logic [NUM_TASKS-1:0]      wrap_vec;
    logic [NUM_TASKS*PC_W-1:0] pc_vec;
    logic [NUM_TASKS*2-1:0]    task_state;

    for (genvar t = 0; t < NUM_TASKS; t++) begin : g_ctx
        logic hit_t;
        assign hit_t = iss_valid && (iss_task == TID_W'(t));

        loop_task_ctx #(
            .PC_W (PC_W),
            .LEN_W(LEN_W),
            .CNT_W(CNT_W)
        ) u_ctx (
            .clk      (clk),
            .rst_n    (rst_n),
            .hit      (hit_t),
            .start    (hit_t && rep_start),
            .abort    (cancel[t]),
            .pc       (iss_pc),
            .long_mode(rep_long),
            .len      (rep_len),
            .count    (rep_count),
            .wrap     (wrap_vec[t]),
            .wrap_pc  (pc_vec[t*PC_W +: PC_W]),
            .state    (task_state[t*2 +: 2])
        );
    end

    loop_redirect_sel #(
        .NT   (NUM_TASKS),
        .TID_W(TID_W),
        .PC_W (PC_W)
    ) u_sel (
        .wrap_vec(wrap_vec),
        .pc_vec  (pc_vec),
        .sel     (iss_task),
        .valid   (redir_valid),
        .pc      (redir_pc)
    );

endmodule

// File: rtl/task_loop_ctrl_chk.sv
module task_loop_ctrl_chk
    import loop_ctrl_pkg::*;
#(
    parameter int NT    = 4,
    parameter int TID_W = 2,
    parameter int PC_W  = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             iss_valid,
    input logic [TID_W-1:0] iss_task,
    input logic [PC_W-1:0]  iss_pc,
    input logic             rep_start,
    input logic [NT-1:0]    cancel,
    input logic             redir_valid,
    input logic [PC_W-1:0]  redir_pc,
    input logic [NT*2-1:0]  task_state
);

    // R11
    redirect_needs_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        redir_valid |-> (iss_valid && !rep_start));

    // R11
    redirect_backward_chk: assert property (@(posedge clk) disable iff (!rst_n)
        redir_valid |-> (redir_pc <= iss_pc));

    // R2
    redirect_owner_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        redir_valid |-> (task_state[iss_task*2 +: 2] != 2'(LP_IDLE)));

    // R8
    redirect_not_cancelled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        redir_valid |-> !cancel[iss_task]);

    for (genvar t = 0; t < NT; t++) begin : g_task
        // R8
        cancel_idles_chk: assert property (@(posedge clk) disable iff (!rst_n)
            cancel[t] |=> (task_state[t*2 +: 2] == 2'(LP_IDLE)));

        // R9
        launch_arms_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (iss_valid && rep_start && (iss_task == TID_W'(t)) && !cancel[t])
            |=> (task_state[t*2 +: 2] == 2'(LP_ARMING)));
    end

endmodule

bind task_loop_ctrl task_loop_ctrl_chk #(
    .NT   (NUM_TASKS),
    .TID_W(TID_W),
    .PC_W (PC_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .iss_valid  (iss_valid),
    .iss_task   (iss_task),
    .iss_pc     (iss_pc),
    .rep_start  (rep_start),
    .cancel     (cancel),
    .redir_valid(redir_valid),
    .redir_pc   (redir_pc),
    .task_state (task_state)
);

// File: tb/task_loop_ctrl_bench.sv
module task_loop_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        iss_valid = 1'b0;
    logic [1:0]  iss_task = '0;
    logic [15:0] iss_pc = '0;
    logic        rep_start = 1'b0;
    logic        rep_long = 1'b0;
    logic [7:0]  rep_len = '0;
    logic [15:0] rep_count = '0;
    logic [3:0]  cancel = '0;
    logic        redir_valid;
    logic [15:0] redir_pc;

    int checks = 0;
    int errors = 0;

    // bench-side expectation of each context
    int m_st [4];   // 0 idle, 1 arming, 2 active
    int m_arm[4];
    int m_lng[4];
    int m_fvr[4];
    int m_beg[4];
    int m_end[4];
    int m_rem[4];

    always #2 clk = ~clk;

    task_loop_ctrl u_task_loop_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .iss_valid  (iss_valid),
        .iss_task   (iss_task),
        .iss_pc     (iss_pc),
        .rep_start  (rep_start),
        .rep_long   (rep_long),
        .rep_len    (rep_len),
        .rep_count  (rep_count),
        .cancel     (cancel),
        .redir_valid(redir_valid),
        .redir_pc   (redir_pc)
    );

    task automatic model_step(input bit v, input int tk, input int pc, input bit st,
                              input bit lg, input int ln, input int cn, input bit [3:0] cx,
                              output bit ev, output int epc);
        int need, passed, eff;
        bit armed;
        ev = 0;
        epc = 0;
        for (int t = 0; t < 4; t++) if (cx[t]) m_st[t] = 0;
        if (v && !cx[tk]) begin
            if (st) begin
                need = lg ? 3 : 1;                       // R10
                eff  = (ln < need) ? need : ln;
                m_st[tk]  = 1;
                m_arm[tk] = 0;
                m_lng[tk] = lg;
                m_fvr[tk] = (cn == 0);
                m_beg[tk] = (pc + 1) & 16'hFFFF;
                m_end[tk] = (pc + eff) & 16'hFFFF;
                m_rem[tk] = cn;
            end else if (m_st[tk] != 0) begin
                need   = m_lng[tk] ? 3 : 1;
                passed = m_arm[tk] + 1;
                armed  = (m_st[tk] == 2) || (passed >= need);
                if (m_st[tk] == 1) begin
                    m_arm[tk] = (passed > 3) ? 3 : passed;
                    if (passed >= need) m_st[tk] = 2;
                end
                if (armed && pc == m_end[tk]) begin
                    if (m_fvr[tk] != 0 || m_rem[tk] > 1) begin
                        ev  = 1;
                        epc = m_beg[tk];
                        if (m_fvr[tk] == 0) m_rem[tk]--;
                    end else begin
                        m_st[tk] = 0;
                    end
                end
            end
        end
    endtask

    task automatic cyc(input bit v, input int tk, input int pc, input bit st, input bit lg,
                       input int ln, input int cn, input bit [3:0] cx, input string tag,
                       output bit ev, output int epc);
        @(posedge clk);
        #1;
        iss_valid = v;
        iss_task  = tk[1:0];
        iss_pc    = pc[15:0];
        rep_start = st;
        rep_long  = lg;
        rep_len   = ln[7:0];
        rep_count = cn[15:0];
        cancel    = cx;
        model_step(v, tk, pc, st, lg, ln, cn, cx, ev, epc);
        #0.5;
        checks++;
        if (redir_valid !== ev || (ev && redir_pc !== epc[15:0])) begin
            errors++;
            $display("FAIL %s: task %0d pc %0d: redirect %b/%0d, expected %b/%0d",
                     tag, tk, pc, redir_valid, redir_pc, ev, epc);
        end
    endtask

    task automatic go(input int tk, input int pc, input string tag);
        bit e; int p;
        cyc(1, tk, pc, 0, 0, 0, 0, 4'h0, tag, e, p);
    endtask

    task automatic launch(input int tk, input int pc, input bit lg, input int ln,
                          input int cn, input string tag);
        bit e; int p;
        cyc(1, tk, pc, 1, lg, ln, cn, 4'h0, tag, e, p);
    endtask

    task automatic abort_tasks(input bit [3:0] cx, input string tag);
        bit e; int p;
        cyc(0, 0, 0, 0, 0, 0, 0, cx, tag, e, p);
    endtask

    initial begin
        #(4 * 150000);
        errors++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int vpc[4];
        bit e; int p;
        void'($urandom(32'h5EED_0042));
        for (int t = 0; t < 4; t++) begin
            m_st[t] = 0; m_arm[t] = 0; m_lng[t] = 0; m_fvr[t] = 0;
            m_beg[t] = 0; m_end[t] = 0; m_rem[t] = 0;
        end
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: idle after reset, no redirect on ordinary issue
        go(0, 50, "R1");
        go(3, 51, "R1");

        // R3 short mode, 3 passes of a one-instruction block
        launch(0, 100, 0, 1, 3, "R3");
        go(0, 101, "R3");
        go(0, 101, "R5");
        go(0, 101, "R6");
        go(0, 101, "R6");

        // R4 long mode with interleaving and an early block end
        launch(1, 200, 1, 3, 2, "R4");
        go(2, 203, "R2");
        go(1, 203, "R4");
        go(3, 500, "R4");
        go(1, 201, "R4");
        go(2, 7,   "R4");
        go(1, 202, "R4");
        go(1, 203, "R5");
        go(1, 201, "R6");
        go(1, 202, "R6");
        go(1, 203, "R6");
        go(1, 203, "R6");

        // R10 length clamping in both modes
        launch(2, 300, 1, 1, 2, "R10");
        go(2, 301, "R10");
        go(2, 302, "R10");
        go(2, 303, "R10");
        launch(3, 400, 0, 0, 2, "R10");
        go(3, 401, "R10");
        go(3, 401, "R10");

        // R7 unlimited loop, R8 cancel
        launch(0, 600, 0, 2, 0, "R7");
        for (int i = 0; i < 12; i++) begin
            go(0, 601, "R7");
            go(0, 602, "R7");
        end
        cyc(1, 0, 602, 0, 0, 0, 0, 4'b0001, "R8", e, p);
        go(0, 601, "R8");
        go(0, 602, "R8");

        // R9 restart of a busy context
        launch(1, 700, 0, 4, 5, "R9");
        go(1, 701, "R9");
        go(1, 702, "R9");
        launch(1, 800, 0, 2, 2, "R9");
        go(1, 704, "R9");
        go(1, 801, "R9");
        go(1, 802, "R9");
        go(1, 801, "R9");
        go(1, 802, "R9");

        // R11 repeat instruction at a block end never redirects
        launch(0, 900, 0, 1, 0, "R11");
        go(0, 901, "R11");
        launch(0, 901, 0, 1, 0, "R11");
        go(0, 902, "R11");

        // R2 same address from another task
        launch(0, 1000, 0, 1, 0, "R2");
        go(1, 1001, "R2");
        go(0, 1001, "R2");
        abort_tasks(4'hF, "R8");
        go(0, 1001, "R8");

        // constrained random phase
        for (int t = 0; t < 4; t++) vpc[t] = 2000 + 100 * t;
        for (int n = 0; n < 6000; n++) begin
            int tk, r, pc;
            bit v, st, lg;
            bit [3:0] cx;
            tk = $urandom % 4;
            v  = ($urandom % 100) < 85;
            r  = $urandom % 100;
            st = v && (r < 7);
            lg = $urandom % 2;
            cx = (($urandom % 100) < 2) ? 4'($urandom % 16) : 4'h0;
            pc = vpc[tk];
            cyc(v, tk, pc, st, lg, $urandom % 6, $urandom % 5, cx, "R5", e, p);
            if (v) begin
                if (e) vpc[tk] = p;
                else if (($urandom % 100) < 3) vpc[tk] = 2000 + 100 * tk + ($urandom % 20);
                else vpc[tk] = pc + 1;
                if (vpc[tk] > 60000) vpc[tk] = 2000 + 100 * tk;
            end
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule